// File: doc/BRIEF.md
# DMA Transfer Descriptor Builder

This block sits in front of a DMA engine that moves data between a host memory (reached over a 64-bit address) and a local memory (reached over a 32-bit address). Software or a control sequencer hands it one transfer request at a time: host address, local address, byte length and a direction bit. The block turns the request into one or two 256-bit command descriptors. It streams them, one 64-bit word per beat, into a circular descriptor queue held in an external memory. Once the last word is stored, it publishes the new queue write pointer, which tells the engine to start.

A short transfer becomes a single one-line descriptor. A long transfer is cut into equal lines of a fixed size, with matching pitch on both sides. If bytes are left over, a one-line tail descriptor carries them, and only that last descriptor asks for the completion interrupt. A busy flag covers the whole time from acceptance until the engine reports completion. No new request is taken while it is set.

Both streaming edges use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and its fields are sampled only on that cycle. The memory write port holds `mem_valid`, `mem_addr` and `mem_wdata` unchanged until `mem_ready` is seen high, so the memory side may stall for any number of cycles. `done` and `start` are plain single-cycle pulses.

Top module: `xfer_desc_builder`

## Requirements
- R1: Each descriptor occupies queue slot s as four consecutive word addresses s*4+0..3, written in this order: host address, pitch word, control word, and a reserved word that is always zero.
- R2: When the length is at most 0x7FFF, one descriptor is built. Its line count (control bits 27:16) is 1. Its local pitch (pitch bits 62:48) and host pitch (pitch bits 46:32) are both 1. Its line size (control bits 14:0) equals the length. Pitch bits 30:0 carry the local address.
- R3: When the length exceeds 0x7FFF, the first descriptor has line count = length / 0x7000 (low 12 bits kept), and line size and both pitches equal to 0x7000. A non-zero remainder adds a second descriptor in the next slot. That descriptor has line count 1, pitches 1, line size equal to the remainder, and both addresses advanced by line count × 0x7000. A zero remainder adds no second descriptor.
- R4: The interrupt-request bit (control bit 37) is set on the last descriptor of a transfer and cleared on any earlier one.
- R5: Control bit 32 equals the direction input. Control bit 40 is set on every descriptor of a transfer when the 64-bit sum of host address and length exceeds 0xFFFF_FFFF.
- R6: The slot index wraps modulo 128. `wptr` equals the slot after the last written descriptor times 2. It changes, together with a one-cycle `start` pulse, on the cycle after the final word handshake, and at no other time.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R8: `req_ready` is high only when no descriptor words are pending and `busy` is low. A request offered at any other time is neither taken nor remembered.
- R9: `busy` rises on the cycle after a request is taken and falls on the cycle after `done` is seen while busy. A `done` pulse while not busy has no effect.
- R10: After reset, `busy`, `mem_valid` and `start` are low, `wptr` is 0, `req_ready` is high and the first descriptor goes to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_host_addr | input | 64 | Host-side start address |
| req_local_addr | input | 32 | Local-side start address |
| req_len | input | 32 | Transfer length in bytes |
| req_upstream | input | 1 | Direction: 1 = local to host |
| mem_valid | output | 1 | Descriptor word write pending |
| mem_ready | input | 1 | Queue memory accepts the word |
| mem_addr | output | 9 | Queue word address (slot*4 + word) |
| mem_wdata | output | 64 | Descriptor word |
| start | output | 1 | One-cycle pulse when wptr is updated |
| wptr | output | 8 | Published queue write pointer |
| busy | output | 1 | Transfer outstanding |
| done | input | 1 | Completion pulse from the engine |

## Verification
The assertions assume that `mem_ready` and `done` are known on every clock edge. They also assume that `done` reports only the transfer that is currently outstanding, so a pulse while idle is merely ignored. The stimulus drives every input half a cycle away from the active edge. It applies `mem_ready` as a random pattern that is low about a quarter of the time, to exercise the hold rule. It raises `done` either a few cycles after `start`, or early while words are still streaming, and once with nothing outstanding. Request fields are changed to junk right after acceptance, to show that only the accepting cycle's values are used.

// File: rtl/xdesc_pkg.sv
package xdesc_pkg;
  typedef logic [63:0] qword_t;

  // Packed so that the host word is the lowest 64 bits.
  typedef struct packed {
    qword_t spare;
    qword_t ctl;
    qword_t pitch;
    qword_t host;
  } desc_t;

  localparam int unsigned QW_PER_DESC  = 4;
  localparam int unsigned QW_IDX_W     = $clog2(QW_PER_DESC);

  localparam int unsigned CTL_WIDE_BIT = 40;
  localparam int unsigned CTL_IRQ_BIT  = 37;
  localparam int unsigned CTL_UP_BIT   = 32;
  localparam int unsigned CTL_CNT_LSB  = 16;
  localparam int unsigned CTL_CNT_W    = 12;
  localparam int unsigned CTL_SIZE_W   = 15;

  localparam int unsigned PT_LOCAL_LSB = 48;
  localparam int unsigned PT_HOST_LSB  = 32;
  localparam int unsigned PT_W         = 15;
  localparam int unsigned PT_ADDR_W    = 31;

  function automatic qword_t make_pitch(input logic [PT_W-1:0] step,
                                        input logic [PT_ADDR_W-1:0] laddr);
    qword_t w;
    w = '0;
    w[PT_LOCAL_LSB +: PT_W] = step;
    w[PT_HOST_LSB +: PT_W]  = step;
    w[PT_ADDR_W-1:0]        = laddr;
    return w;
  endfunction

  function automatic qword_t make_ctl(input logic wide, input logic irq,
                                      input logic up,
                                      input logic [CTL_CNT_W-1:0] cnt,
                                      input logic [CTL_SIZE_W-1:0] size);
    qword_t w;
    w = '0;
    w[CTL_WIDE_BIT]               = wide;
    w[CTL_IRQ_BIT]                = irq;
    w[CTL_UP_BIT]                 = up;
    w[CTL_CNT_LSB +: CTL_CNT_W]   = cnt;
    w[CTL_SIZE_W-1:0]             = size;
    return w;
  endfunction
endpackage

// File: rtl/xdesc_calc.sv
// Combinational split of one request into a head and an optional tail descriptor.
module xdesc_calc
  import xdesc_pkg::*;
#(
  parameter logic [31:0] LINE_BYTES = 32'h7000,
  parameter logic [31:0] SINGLE_MAX = 32'h7FFF
) (
  input  logic [63:0] host_addr,
  input  logic [31:0] local_addr,
  input  logic [31:0] len,
  input  logic        upstream,
  output desc_t       head_desc,
  output desc_t       tail_desc,
  output logic        has_tail
);
  logic        long_xfer;
  logic        wide;
  logic [31:0] n_lines;
  logic [31:0] span;
  logic [31:0] rest;
  logic [31:0] tail_local;
  logic [63:0] end_addr;

  always_comb begin
    long_xfer  = len > SINGLE_MAX;
    n_lines    = len / LINE_BYTES;
    span       = n_lines * LINE_BYTES;
    rest       = len - span;
    has_tail   = long_xfer && (rest != '0);
    end_addr   = host_addr + {32'h0, len};
    wide       = end_addr > 64'hFFFF_FFFF;
    tail_local = local_addr + span;

    head_desc.host  = host_addr;
    head_desc.spare = '0;
    head_desc.pitch = make_pitch(long_xfer ? LINE_BYTES[PT_W-1:0] : PT_W'(1),
                                 local_addr[PT_ADDR_W-1:0]);
    head_desc.ctl   = make_ctl(wide, !has_tail, upstream,
                               long_xfer ? n_lines[CTL_CNT_W-1:0] : CTL_CNT_W'(1),
                               long_xfer ? LINE_BYTES[CTL_SIZE_W-1:0] : len[CTL_SIZE_W-1:0]);

    tail_desc.host  = host_addr + {32'h0, span};
    tail_desc.spare = '0;
    tail_desc.pitch = make_pitch(PT_W'(1), tail_local[PT_ADDR_W-1:0]);
    tail_desc.ctl   = make_ctl(wide, 1'b1, upstream, CTL_CNT_W'(1),
                               rest[CTL_SIZE_W-1:0]);
  end
endmodule

// File: rtl/xdesc_slot_ring.sv
// Queue head index with wrap; the wrap logic depends on whether SLOTS is a power of two.
module xdesc_slot_ring #(
  parameter  int unsigned SLOTS  = 128,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              two,
  output logic [SLOT_W-1:0] head,
  output logic [SLOT_W-1:0] head_nx1
);
  logic [SLOT_W-1:0] head_nx2;

  if ((SLOTS & (SLOTS - 1)) == 0) begin : g_pow2
    assign head_nx1 = head + SLOT_W'(1);
    assign head_nx2 = head + SLOT_W'(2);
  end else begin : g_mod
    assign head_nx1 = (head == SLOT_W'(SLOTS - 1)) ? '0 : head + SLOT_W'(1);
    assign head_nx2 = (head >= SLOT_W'(SLOTS - 2)) ? head - SLOT_W'(SLOTS - 2)
                                                    : head + SLOT_W'(2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      head <= '0;
    else if (commit) head <= two ? head_nx2 : head_nx1;
  end
endmodule

// File: rtl/xdesc_writer.sv
// Streams held descriptors to the queue memory, one 64-bit word per handshake.
module xdesc_writer
  import xdesc_pkg::*;
#(
  parameter  int unsigned SLOT_W = 7,
  localparam int unsigned AW     = SLOT_W + QW_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  desc_t             desc_a,
  input  desc_t             desc_b,
  input  logic              two,
  input  logic [SLOT_W-1:0] slot_a,
  input  logic [SLOT_W-1:0] slot_b,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [AW-1:0]     mem_addr,
  output logic [63:0]       mem_wdata,
  output logic              idle,
  output logic              last_hs
);
  logic [QW_PER_DESC*64-1:0] held   [2];
  logic [SLOT_W-1:0]         slot_q [2];
  qword_t                    lane   [2][QW_PER_DESC];
  logic                      two_q;
  logic                      active;
  logic                      sel;
  logic [QW_IDX_W-1:0]       widx;
  logic                      hs;
  logic                      last_word;

  for (genvar d = 0; d < 2; d++) begin : g_desc
    for (genvar w = 0; w < QW_PER_DESC; w++) begin : g_word
      assign lane[d][w] = held[d][w*64 +: 64];
    end
  end

  assign mem_valid = active;
  assign mem_addr  = {slot_q[sel], widx};
  assign mem_wdata = lane[sel][widx];
  assign idle      = !active;
  assign hs        = active && mem_ready;
  assign last_word = widx == QW_IDX_W'(QW_PER_DESC - 1);
  assign last_hs   = hs && last_word && (sel || !two_q);

  // Datapath capture, no reset needed.
  always_ff @(posedge clk) begin
    if (load) begin
      held[0]   <= desc_a;
      held[1]   <= desc_b;
      slot_q[0] <= slot_a;
      slot_q[1] <= slot_b;
      two_q     <= two;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      sel    <= 1'b0;
      widx   <= '0;
    end else if (load) begin
      active <= 1'b1;
      sel    <= 1'b0;
      widx   <= '0;
    end else if (hs) begin
      if (last_word) begin
        widx <= '0;
        if (last_hs) active <= 1'b0;
        else         sel    <= 1'b1;
      end else begin
        widx <= widx + QW_IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/xfer_desc_builder.sv
module xfer_desc_builder
  import xdesc_pkg::*;
#(
  parameter  int unsigned SLOTS      = 128,
  parameter  logic [31:0] LINE_BYTES = 32'h7000,
  parameter  logic [31:0] SINGLE_MAX = 32'h7FFF,
  parameter  int unsigned PTR_UNIT   = 2,
  localparam int unsigned SLOT_W     = $clog2(SLOTS),
  localparam int unsigned MEM_AW     = SLOT_W + QW_IDX_W,
  localparam int unsigned PTR_W      = $clog2(SLOTS * PTR_UNIT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_host_addr,
  input  logic [31:0]       req_local_addr,
  input  logic [31:0]       req_len,
  input  logic              req_upstream,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  output logic              start,
  output logic [PTR_W-1:0]  wptr,
  output logic              busy,
  input  logic              done
);
  desc_t             head_desc;
  desc_t             tail_desc;
  logic              has_tail;
  logic              wr_idle;
  logic              wr_last;
  logic              accept;
  logic              two_q;
  logic [SLOT_W-1:0] head;
  logic [SLOT_W-1:0] head_nx1;

  assign req_ready = wr_idle && !busy;
  assign accept    = req_valid && req_ready;

  xdesc_calc #(
    .LINE_BYTES(LINE_BYTES),
    .SINGLE_MAX(SINGLE_MAX)
  ) u_calc (
    .host_addr (req_host_addr),
    .local_addr(req_local_addr),
    .len       (req_len),
    .upstream  (req_upstream),
    .head_desc (head_desc),
    .tail_desc (tail_desc),
    .has_tail  (has_tail)
  );

  xdesc_writer #(
    .SLOT_W(SLOT_W)
  ) u_writer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .desc_a   (head_desc),
    .desc_b   (tail_desc),
    .two      (has_tail),
    .slot_a   (head),
    .slot_b   (head_nx1),
    .mem_ready(mem_ready),
    .mem_valid(mem_valid),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .idle     (wr_idle),
    .last_hs  (wr_last)
  );

  xdesc_slot_ring #(
    .SLOTS(SLOTS)
  ) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (wr_last),
    .two     (two_q),
    .head    (head),
    .head_nx1(head_nx1)
  );

  // Head index only moves at commit, so the pointer follows it directly.
  assign wptr = PTR_W'(head) * PTR_W'(PTR_UNIT);

  always_ff @(posedge clk) begin
    if (accept) two_q <= has_tail;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      start <= 1'b0;
    end else begin
      start <= wr_last;
      if (accept)    busy <= 1'b1;
      else if (done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/xdesc_checker.sv
module xdesc_checker #(
  parameter int unsigned MEM_AW = 9,
  parameter int unsigned PTR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [63:0]       mem_wdata,
  input logic              start,
  input logic [PTR_W-1:0]  wptr,
  input logic              busy,
  input logic              done
);
  p_spare_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && (mem_addr[1:0] == 2'd3) |-> mem_wdata == 64'd0);

  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  p_start_after_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(mem_valid && mem_ready));

  p_wptr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !start |-> $stable(wptr));

  p_wptr_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wptr[0] == 1'b0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata));

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy && !mem_valid);

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && mem_valid);

  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && done |=> !busy);
endmodule

bind xfer_desc_builder xdesc_checker #(
  .MEM_AW(MEM_AW),
  .PTR_W (PTR_W)
) u_xdesc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .mem_valid(mem_valid),
  .mem_ready(mem_ready),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .start    (start),
  .wptr     (wptr),
  .busy     (busy),
  .done     (done)
);

// File: tb/test_xfer_desc_builder.sv
module test_xfer_desc_builder;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 128;
  localparam int LINE       = 28672;  // 0x7000
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_host_addr = '0;
  logic [31:0] req_local_addr = '0;
  logic [31:0] req_len = '0;
  logic        req_upstream = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [8:0]  mem_addr;
  logic [63:0] mem_wdata;
  logic        start;
  logic [7:0]  wptr;
  logic        busy;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_desc_builder i_xfer_desc_builder (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_host_addr(req_host_addr), .req_local_addr(req_local_addr),
    .req_len(req_len), .req_upstream(req_upstream),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .start(start), .wptr(wptr), .busy(busy), .done(done)
  );

  // ---------------- behavioural reference model ----------------
  typedef struct {
    int unsigned addr;
    logic [63:0] data;
    string       tag;
  } exp_wr_t;

  exp_wr_t     exp_q[$];
  bit          m_idle = 1'b1;
  bit          m_busy = 1'b0;
  bit          m_start = 1'b0;
  int unsigned m_slot = 0;
  int unsigned m_wptr = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  int          cycles = 0;
  bit          ready_random = 1'b0;
  bit          finished = 1'b0;

  function automatic void push_desc(int unsigned slot, logic [63:0] host,
                                    logic [31:0] laddr, int unsigned cnt,
                                    int unsigned size, int unsigned step,
                                    bit wide, bit irq, bit up, string tag);
    logic [63:0] pw, cw;
    exp_wr_t e;
    pw = (64'(step) << 48) | (64'(step) << 32) | {33'b0, laddr[30:0]};
    cw = (64'(wide) << 40) | (64'(irq) << 37) | (64'(up) << 32) |
         (64'(cnt & 32'hFFF) << 16) | 64'(size);
    e.addr = slot*4 + 0; e.data = host;  e.tag = "R1";                         exp_q.push_back(e);
    e.addr = slot*4 + 1; e.data = pw;    e.tag = tag;                          exp_q.push_back(e);
    e.addr = slot*4 + 2; e.data = cw;    e.tag = $sformatf("%s/R4/R5", tag);   exp_q.push_back(e);
    e.addr = slot*4 + 3; e.data = 64'd0; e.tag = "R1";                         exp_q.push_back(e);
  endfunction

  function automatic void build(logic [63:0] host, logic [31:0] laddr,
                                logic [31:0] len, bit up);
    logic [63:0] sum;
    bit          wide;
    int unsigned lines, span, rest;
    sum  = host + {32'h0, len};
    wide = sum > 64'hFFFF_FFFF;
    if (len <= 32'h7FFF) begin
      push_desc(m_slot, host, laddr, 1, len, 1, wide, 1'b1, up, "R2");
      m_slot = (m_slot + 1) % SLOTS;
    end else begin
      lines = len / LINE;
      span  = lines * LINE;
      rest  = len - span;
      push_desc(m_slot, host, laddr, lines, LINE, LINE, wide, rest == 0, up, "R3");
      m_slot = (m_slot + 1) % SLOTS;
      if (rest != 0) begin
        push_desc(m_slot, host + 64'(span), laddr + span, 1, rest, 1, wide, 1'b1, up, "R3");
        m_slot = (m_slot + 1) % SLOTS;
      end
    end
  endfunction

  always @(posedge clk) begin
    bit acc, hs;
    if (!rst_n) begin
      exp_q.delete();
      m_idle = 1'b1; m_busy = 1'b0; m_start = 1'b0; m_slot = 0; m_wptr = 0;
    end else begin
      acc = m_idle && !m_busy && req_valid;
      hs  = !m_idle && mem_ready;
      m_start = 1'b0;
      if (hs) begin
        void'(exp_q.pop_front());
        if (exp_q.size() == 0) begin
          m_idle  = 1'b1;
          m_wptr  = m_slot * 2;
          m_start = 1'b1;
        end
      end
      if (acc) begin
        build(req_host_addr, req_local_addr, req_len, req_upstream);
        m_idle = 1'b0;
        m_busy = 1'b1;
      end else if (done) begin
        m_busy = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      summary();
    end
    if (rst_n) begin
      check(req_ready === (m_idle && !m_busy), "R8", "req_ready", 64'(req_ready), 64'(m_idle && !m_busy));
      check(busy === m_busy, "R9", "busy", 64'(busy), 64'(m_busy));
      check(mem_valid === !m_idle, "R7", "mem_valid", 64'(mem_valid), 64'(!m_idle));
      check(start === m_start, "R6", "start", 64'(start), 64'(m_start));
      check(int'(wptr) == m_wptr, "R6", "wptr", 64'(wptr), 64'(m_wptr));
      if (!m_idle && exp_q.size() > 0) begin
        check(int'(mem_addr) == exp_q[0].addr, "R1/R6", "mem_addr", 64'(mem_addr), 64'(exp_q[0].addr));
        check(mem_wdata === exp_q[0].data, exp_q[0].tag, "mem_wdata", mem_wdata, exp_q[0].data);
      end
    end
  end

  // Memory-side back-pressure pattern (R7).
  always @(negedge clk) begin
    if (ready_random) mem_ready = ($urandom % 4) != 0;
    else              mem_ready = 1'b1;
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [63:0] h, input logic [31:0] la,
                      input logic [31:0] ln, input bit up);
    @(negedge clk);
    req_host_addr = h; req_local_addr = la; req_len = ln; req_upstream = up;
    req_valid = 1'b1;
    while (!(m_idle && !m_busy)) @(negedge clk);
    @(negedge clk);
    req_valid      = 1'b0;
    req_host_addr  = 64'hDEAD_BEEF_DEAD_BEEF;
    req_local_addr = 32'hBAD0_BAD0;
    req_len        = 32'h0001_2345;
    req_upstream   = ~up;
  endtask

  task automatic wait_publish();
    do @(negedge clk); while (!m_start);
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic xfer(input logic [63:0] h, input logic [31:0] la,
                      input logic [31:0] ln, input bit up);
    send(h, la, ln, up);
    wait_publish();
    repeat (2) @(negedge clk);
    pulse_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(busy === 1'b0 && mem_valid === 1'b0 && start === 1'b0, "R10", "flags", {61'd0, busy, mem_valid, start}, 64'd0);
    check(wptr === 8'd0, "R10", "wptr", 64'(wptr), 64'd0);
    check(req_ready === 1'b1, "R10", "req_ready", 64'(req_ready), 64'd1);

    // R2: short and boundary-length single descriptors
    xfer(64'h0000_0000_1000_0000, 32'h0000_4000, 32'h100, 1'b0);
    xfer(64'h0000_0000_2000_0000, 32'hFFFF_0000, 32'h7FFF, 1'b1);
    xfer(64'h0000_0000_2100_0000, 32'h0000_0100, 32'h7000, 1'b0);
    xfer(64'h0000_0000_2200_0000, 32'h0000_0200, 32'h0, 1'b1);
    // R3/R4: split with remainder, exact multiple, large split
    xfer(64'h0000_0000_3000_0000, 32'h0001_0000, 32'h8000, 1'b0);
    xfer(64'h0000_0000_3100_0000, 32'h0002_0000, 32'hE000, 1'b1);
    xfer(64'h0000_0000_3200_0000, 32'h7FFF_F000, 32'h2_0000, 1'b0);
    // R5: end address crosses 4 GiB, and an address already above it
    xfer(64'h0000_0000_FFFF_F000, 32'h0000_1000, 32'h2000, 1'b1);
    xfer(64'h0000_0000_FFFF_0000, 32'h0000_2000, 32'h1_0000, 1'b0);
    xfer(64'h0000_0001_0000_0000, 32'h0000_3000, 32'h40, 1'b1);

    // R9: done while idle has no effect
    pulse_done();
    repeat (3) @(negedge clk);

    // R8: request offered while busy is held off until done
    send(64'h0000_0000_4000_0000, 32'h10, 32'h200, 1'b0);
    wait_publish();
    fork
      send(64'h0000_0000_4100_0000, 32'h20, 32'h9000, 1'b1);
      begin repeat (6) @(negedge clk); pulse_done(); end
    join
    wait_publish();
    pulse_done();

    // R7/R9: back-pressure, early done while words still stream
    ready_random = 1'b1;
    send(64'h0000_0000_5000_0000, 32'h30, 32'h1_5000, 1'b0);
    pulse_done();
    wait_publish();
    repeat (2) @(negedge clk);

    // R6: many transfers to wrap the slot index
    for (int k = 0; k < 90; k++) begin
      logic [63:0] h;
      h = {$urandom, $urandom};
      if (k % 3 == 0) h[63:32] = 32'h0;
      xfer(h, $urandom, $urandom % 32'h3_0000, 1'($urandom % 2));
    end

    ready_random = 1'b0;
    repeat (4) @(negedge clk);
    summary();
  end
endmodule